// File: doc/BRIEF.md
# Virtual-8086 Interrupt-Return Flag Merge Unit

This unit settles the outcome of an interrupt return issued while the processor runs in virtual-8086 mode. The return frame has already been read from the stack by other logic. The unit receives the popped instruction pointer, code selector and flags word, together with the live flags register and the virtual-mode-extensions enable. From these it computes one result. That result is either a general-protection fault request, whose error code is always zero, or a new code selector, a new instruction pointer and a merged flags register.

The decision and the merge are combinational. Both land in one output register, so every request yields exactly one single-cycle pulse, on either the fault output or the result-valid output. The privilege level and the pending-virtual-interrupt bit are read from the live flags input. The popped flags input counts in full for a 32-bit return. For a 16-bit return, only its low half counts.

Top module: `v86_iret_merge`

## Requirements
- R1: A 16-bit return (`req_wide`=0) with IOPL (flags bits 13:12) below 3 and the extensions disabled (`ext_en`=0) yields a fault.
- R2: A 16-bit return with IOPL below 3 and the extensions enabled yields a fault when the popped TF (bit 8) is 1, or when the popped IF (bit 9) and the live VIP (bit 20) are both 1.
- R3: A 16-bit return with IOPL below 3, the extensions enabled and no R2 fault takes CF(0), PF(2), AF(4), ZF(6), SF(7), TF(8), DF(10), OF(11) and NT(14) from the popped word. It sets VIF (bit 19) to the popped IF. Every other defined bit keeps its live value, including IF(9), IOPL(13:12), RF(16), VM(17), AC(18), VIP(20) and ID(21).
- R4: A 16-bit return with IOPL equal to 3 never faults, whatever `ext_en` is. It takes CF, PF, AF, ZF, SF, TF, IF, DF, OF and NT from the popped word and keeps IOPL and bits 16 to 21 at their live values.
- R5: A 32-bit return (`req_wide`=1) yields a fault whenever IOPL is below 3, whatever `ext_en` is.
- R6: A 32-bit return with IOPL equal to 3 takes CF, PF, AF, ZF, SF, TF, IF, DF, OF, NT, RF, AC and ID from the popped flags. It keeps IOPL, VM, VIF and VIP at their live values.
- R7: On a result, `res_cs` is the popped selector. `res_ip` is the popped pointer for a 32-bit return, and for a 16-bit return it is the low 16 bits of the popped pointer, zero-extended.
- R8: In every merged flags result, bit 1 reads 1, and bits 3, 5, 15 and 22 to 31 read 0.
- R9: After reset, `res_fault` and `res_valid` are 0. A request sampled on one rising edge raises exactly one of them for exactly the following cycle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A return frame is presented this cycle |
| req_wide | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| ext_en | input | 1 | Virtual-mode extensions enable |
| pop_ip | input | IP_W | Popped instruction pointer |
| pop_cs | input | SEL_W | Popped code selector |
| pop_flags | input | FLAG_W | Popped flags image |
| live_flags | input | FLAG_W | Current flags register (IOPL and VIP are read from it) |
| res_fault | output | 1 | General-protection fault request, error code zero |
| res_valid | output | 1 | Result fields below are valid |
| res_cs | output | SEL_W | New code selector |
| res_ip | output | IP_W | New instruction pointer |
| res_flags | output | FLAG_W | Merged flags register |

## Verification
Every outcome of this unit is due one rising edge after the edge that sampled the request: the fault bit, the valid bit and the three result fields all come from a single register stage. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a cycle after that registering edge. It then drops the request and reads both strobes once more one cycle later, to confirm that the pulse lasted only one cycle. The sweep covers both operand sizes, the extension enable, all four privilege levels, VIP and the popped TF/IF combinations. The remaining bits are filled with pseudo-random values, and the expected fields are formed from literal masks.

// File: rtl/v86_iret_pkg.sv
package v86_iret_pkg;
   // architectural flag bit positions; neighbours decode these
   localparam int P_CF   = 0;
   localparam int P_ONE  = 1;
   localparam int P_PF   = 2;
   localparam int P_AF   = 4;
   localparam int P_ZF   = 6;
   localparam int P_SF   = 7;
   localparam int P_TF   = 8;
   localparam int P_IF   = 9;
   localparam int P_DF   = 10;
   localparam int P_OF   = 11;
   localparam int P_IOPL = 12;
   localparam int P_NT   = 14;
   localparam int P_RF   = 16;
   localparam int P_VM   = 17;
   localparam int P_AC   = 18;
   localparam int P_VIF  = 19;
   localparam int P_VIP  = 20;
   localparam int P_ID   = 21;
   localparam int P_TOP  = P_ID;
   localparam int NARROW_W = 16;

   typedef enum logic [1:0] {
      RES_IDLE  = 2'd0,
      RES_FAULT = 2'd1,
      RES_DONE  = 2'd2
   } res_kind_e;

   function automatic logic bit_defined(input int pos);
      return (pos <= P_TOP) && (pos != 3) && (pos != 5) && (pos != 15) && (pos != P_ONE);
   endfunction
endpackage

// File: rtl/v86_iret_check.sv
module v86_iret_check
   import v86_iret_pkg::*;
#(
   parameter bit HAS_VME = 1'b1
) (
   input  logic       wide,
   input  logic       ext_en,
   input  logic [1:0] iopl,
   input  logic       vip,
   input  logic       pop_tf,
   input  logic       pop_if,
   output logic       fault,
   output logic       ext_path
);
   logic ext_on;
   logic top_priv;

   generate
      if (HAS_VME) begin : g_ext
         assign ext_on = ext_en;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_en;
         assign ext_on     = 1'b0;
      end
   endgenerate

   assign top_priv = (iopl == 2'b11);

   always_comb begin
      ext_path = 1'b0;
      if (top_priv) begin
         fault = 1'b0;
      end else if (wide) begin
         fault = 1'b1;
      end else if (!ext_on) begin
         fault = 1'b1;
      end else begin
         fault    = pop_tf | (pop_if & vip);
         ext_path = 1'b1;
      end
   end
endmodule

// File: rtl/v86_iret_flagmix.sv
module v86_iret_flagmix
   import v86_iret_pkg::*;
#(
   parameter int FLAG_W = 32
) (
   input  logic              wide,
   input  logic              ext_path,
   input  logic [FLAG_W-1:0] live,
   input  logic [FLAG_W-1:0] popped,
   output logic [FLAG_W-1:0] merged
);
   localparam logic [FLAG_W-1:0] ONE     = FLAG_W'(1);
   localparam logic [FLAG_W-1:0] M_ARITH = (ONE << P_CF) | (ONE << P_PF) | (ONE << P_AF)
                                         | (ONE << P_ZF) | (ONE << P_SF) | (ONE << P_OF);
   localparam logic [FLAG_W-1:0] M_BASE  = M_ARITH | (ONE << P_TF) | (ONE << P_DF) | (ONE << P_NT);
   localparam logic [FLAG_W-1:0] M_WIDE  = M_BASE | (ONE << P_IF) | (ONE << P_RF)
                                         | (ONE << P_AC) | (ONE << P_ID);
   localparam logic [FLAG_W-1:0] M_EXT   = M_BASE | (ONE << P_VIF);
   localparam logic [FLAG_W-1:0] M_NAR   = M_BASE | (ONE << P_IF);

   logic [FLAG_W-1:0] defined;
   logic [FLAG_W-1:0] src;
   logic [FLAG_W-1:0] wmask;
   logic [FLAG_W-1:0] raw;

   for (genvar g = 0; g < FLAG_W; g++) begin : g_def
      assign defined[g] = bit_defined(g);
   end

   always_comb begin
      if (wide) begin
         src   = popped;
         wmask = M_WIDE;
      end else begin
         src   = {{(FLAG_W-NARROW_W){1'b0}}, popped[NARROW_W-1:0]};
         wmask = ext_path ? M_EXT : M_NAR;
         if (ext_path) src[P_VIF] = popped[P_IF];
      end
      raw    = (live & ~wmask) | (src & wmask);
      merged = (raw & defined) | (ONE << P_ONE);
   end
endmodule

// File: rtl/v86_iret_ptr.sv
module v86_iret_ptr #(
   parameter int IP_W = 32
) (
   input  logic            wide,
   input  logic [IP_W-1:0] pop_ip,
   output logic [IP_W-1:0] new_ip
);
   localparam int LOW_W = 16;

   generate
      if (IP_W > LOW_W) begin : g_ext
         assign new_ip = wide ? pop_ip : {{(IP_W-LOW_W){1'b0}}, pop_ip[LOW_W-1:0]};
      end else begin : g_flat
         logic unused_w;
         assign unused_w = wide;
         assign new_ip   = pop_ip;
      end
   endgenerate
endmodule

// File: rtl/v86_iret_merge.sv
module v86_iret_merge
   import v86_iret_pkg::*;
#(
   parameter int FLAG_W  = 32,
   parameter int IP_W    = 32,
   parameter int SEL_W   = 16,
   parameter bit HAS_VME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_wide,
   input  logic              ext_en,
   input  logic [IP_W-1:0]   pop_ip,
   input  logic [SEL_W-1:0]  pop_cs,
   input  logic [FLAG_W-1:0] pop_flags,
   input  logic [FLAG_W-1:0] live_flags,
   output logic              res_fault,
   output logic              res_valid,
   output logic [SEL_W-1:0]  res_cs,
   output logic [IP_W-1:0]   res_ip,
   output logic [FLAG_W-1:0] res_flags
);
   generate
      if (FLAG_W <= P_TOP) begin : g_bad_flag
         $error("FLAG_W must cover every defined flag bit");
      end
      if (IP_W < 16) begin : g_bad_ip
         $error("IP_W must be at least 16");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("SEL_W must be positive");
      end
   endgenerate

   logic              fault_c;
   logic              ext_path_c;
   logic [FLAG_W-1:0] flags_c;
   logic [IP_W-1:0]   ip_c;
   res_kind_e         kind_c;
   res_kind_e         kind_q;

   v86_iret_check #(.HAS_VME(HAS_VME)) u_check (
      .wide     (req_wide),
      .ext_en   (ext_en),
      .iopl     (live_flags[P_IOPL+1:P_IOPL]),
      .vip      (live_flags[P_VIP]),
      .pop_tf   (pop_flags[P_TF]),
      .pop_if   (pop_flags[P_IF]),
      .fault    (fault_c),
      .ext_path (ext_path_c)
   );

   v86_iret_flagmix #(.FLAG_W(FLAG_W)) u_mix (
      .wide     (req_wide),
      .ext_path (ext_path_c),
      .live     (live_flags),
      .popped   (pop_flags),
      .merged   (flags_c)
   );

   v86_iret_ptr #(.IP_W(IP_W)) u_ptr (
      .wide   (req_wide),
      .pop_ip (pop_ip),
      .new_ip (ip_c)
   );

   always_comb begin
      if (!req_valid)   kind_c = RES_IDLE;
      else if (fault_c) kind_c = RES_FAULT;
      else              kind_c = RES_DONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q    <= RES_IDLE;
         res_cs    <= '0;
         res_ip    <= '0;
         res_flags <= '0;
      end else begin
         kind_q <= kind_c;
         if (kind_c == RES_DONE) begin
            res_cs    <= pop_cs;
            res_ip    <= ip_c;
            res_flags <= flags_c;
         end
      end
   end

   assign res_fault = (kind_q == RES_FAULT);
   assign res_valid = (kind_q == RES_DONE);
endmodule

// File: rtl/v86_iret_props.sv
module v86_iret_props
   import v86_iret_pkg::*;
#(
   parameter int FLAG_W  = 32,
   parameter int IP_W    = 32,
   parameter bit HAS_VME = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_wide,
   input logic              ext_en,
   input logic [FLAG_W-1:0] pop_flags,
   input logic [FLAG_W-1:0] live_flags,
   input logic              res_fault,
   input logic              res_valid,
   input logic [IP_W-1:0]   res_ip,
   input logic [FLAG_W-1:0] res_flags
);
   logic              c_req, c_wide, c_ext;
   logic [FLAG_W-1:0] c_pop, c_live;
   logic              c_low_priv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_req  <= 1'b0;
         c_wide <= 1'b0;
         c_ext  <= 1'b0;
         c_pop  <= '0;
         c_live <= '0;
      end else begin
         c_req  <= req_valid;
         c_wide <= req_wide;
         c_ext  <= ext_en & HAS_VME;
         c_pop  <= pop_flags;
         c_live <= live_flags;
      end
   end

   assign c_low_priv = (c_live[P_IOPL+1:P_IOPL] != 2'b11);

   logic unused_bits;
   assign unused_bits = ^{c_pop, c_live, res_ip[15:0], res_flags};

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_fault && res_valid));
   assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_fault || res_valid) == c_req);
   assert_wide_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && c_wide && c_low_priv) |-> res_fault);
   assert_plain_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && !c_wide && c_low_priv && !c_ext) |-> res_fault);
   assert_pend_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && !c_wide && c_low_priv && c_ext &&
       (c_pop[P_TF] || (c_pop[P_IF] && c_live[P_VIP]))) |-> res_fault);
   assert_vif_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !c_wide && c_low_priv) |->
      (res_flags[P_VIF] == c_pop[P_IF] && res_flags[P_IF] == c_live[P_IF] &&
       res_flags[P_IOPL+1:P_IOPL] == c_live[P_IOPL+1:P_IOPL]));
   assert_keep_iopl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !c_wide) |->
      (res_flags[P_IOPL+1:P_IOPL] == c_live[P_IOPL+1:P_IOPL] &&
       res_flags[P_VIP] == c_live[P_VIP] && res_flags[P_VM] == c_live[P_VM]));
   assert_wide_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && c_wide) |->
      (res_flags[P_VIF] == c_live[P_VIF] && res_flags[P_VIP] == c_live[P_VIP] &&
       res_flags[P_VM] == c_live[P_VM] && res_flags[P_IOPL+1:P_IOPL] == 2'b11));
   assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !c_wide) |-> (res_ip[IP_W-1:16] == '0));
   assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_flags[P_ONE] && !res_flags[3] && !res_flags[5] &&
                     !res_flags[15] && res_flags[FLAG_W-1:P_TOP+1] == '0));
endmodule

bind v86_iret_merge v86_iret_props #(
   .FLAG_W (FLAG_W),
   .IP_W   (IP_W),
   .HAS_VME(HAS_VME)
) u_props (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_wide   (req_wide),
   .ext_en     (ext_en),
   .pop_flags  (pop_flags),
   .live_flags (live_flags),
   .res_fault  (res_fault),
   .res_valid  (res_valid),
   .res_ip     (res_ip),
   .res_flags  (res_flags)
);

// File: tb/sim_v86_iret_merge.sv
module sim_v86_iret_merge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_wide = 1'b0;
   logic        ext_en = 1'b0;
   logic [31:0] pop_ip = '0;
   logic [15:0] pop_cs = '0;
   logic [31:0] pop_flags = '0;
   logic [31:0] live_flags = '0;
   logic        res_fault, res_valid;
   logic [15:0] res_cs;
   logic [31:0] res_ip, res_flags;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   v86_iret_merge u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
      .ext_en(ext_en), .pop_ip(pop_ip), .pop_cs(pop_cs), .pop_flags(pop_flags),
      .live_flags(live_flags), .res_fault(res_fault), .res_valid(res_valid),
      .res_cs(res_cs), .res_ip(res_ip), .res_flags(res_flags)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // writable-bit masks written as literals from the requirement bit lists
   function automatic logic [31:0] want_flags(input logic wide, input logic ext,
                                              input logic [31:0] live, input logic [31:0] pop);
      logic [31:0] m;
      logic [31:0] r;
      logic [1:0]  pl;
      pl = live[13:12];
      if (wide)             m = 32'h0025_4FD5;
      else if (pl != 2'd3)  m = 32'h0000_4DD5;
      else                  m = 32'h0000_4FD5;
      r = (live & ~m) | (pop & m);
      if (!wide && pl != 2'd3 && ext) r[19] = pop[9];
      r = r & 32'h003F_7FD5;
      r[1] = 1'b1;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset fault", {31'd0, res_fault}, 32'd0);
      chk("R9 reset valid", {31'd0, res_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle valid", {31'd0, res_valid}, 32'd0);

      for (int w = 0; w < 2; w++) begin
         for (int e = 0; e < 2; e++) begin
            for (int pl = 0; pl < 4; pl++) begin
               for (int vp = 0; vp < 2; vp++) begin
                  for (int tfif = 0; tfif < 4; tfif++) begin
                     logic [31:0] lv, pf;
                     logic        exp_f;
                     string       ftag, gtag;
                     lv = $urandom;
                     pf = $urandom;
                     lv[17] = 1'b1;
                     lv[13:12] = pl[1:0];
                     lv[20] = vp[0];
                     pf[8] = tfif[0];
                     pf[9] = tfif[1];
                     req_valid  = 1'b1;
                     req_wide   = w[0];
                     ext_en     = e[0];
                     live_flags = lv;
                     pop_flags  = pf;
                     pop_ip     = $urandom;
                     pop_cs     = 16'($urandom);
                     if (pl == 3) begin
                        exp_f = 1'b0;
                        ftag = w ? "R6 no fault" : "R4 no fault";
                        gtag = w ? "R6 flags" : "R4 flags";
                     end else if (w == 1) begin
                        exp_f = 1'b1;
                        ftag = "R5 fault";
                        gtag = "R6 flags";
                     end else if (e == 0) begin
                        exp_f = 1'b1;
                        ftag = "R1 fault";
                        gtag = "R3 flags";
                     end else begin
                        exp_f = tfif[0] | (tfif[1] & vp[0]);
                        ftag = "R2 fault";
                        gtag = "R3 flags";
                     end
                     @(negedge clk);
                     chk(ftag, {31'd0, res_fault}, {31'd0, exp_f});
                     chk("R9 valid", {31'd0, res_valid}, {31'd0, ~exp_f});
                     if (!exp_f) begin
                        chk(gtag, res_flags, want_flags(w[0], e[0], lv, pf));
                        chk("R8 reserved", res_flags & 32'hFFC0_802A, 32'h0000_0002);
                        chk("R7 ip", res_ip, w ? pop_ip : {16'd0, pop_ip[15:0]});
                        chk("R7 cs", {16'd0, res_cs}, {16'd0, pop_cs});
                     end
                     req_valid = 1'b0;
                     @(negedge clk);
                     chk("R9 pulse", {30'd0, res_fault, res_valid}, 32'd0);
                  end
               end
            end
         end
      end

      // back-to-back requests: fault then result on consecutive cycles
      req_valid = 1'b1; req_wide = 1'b1; live_flags = 32'h0002_0000; pop_flags = 32'h0;
      @(negedge clk);
      live_flags = 32'h0002_3000; pop_flags = 32'hFFFF_FFFF; pop_ip = 32'h1234_5678;
      chk("R5 b2b fault", {30'd0, res_fault, res_valid}, 32'd2);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 b2b valid", {30'd0, res_fault, res_valid}, 32'd1);
      chk("R6 all ones", res_flags, 32'h0027_7FD7);
      chk("R7 wide ip", res_ip, 32'h1234_5678);
      @(negedge clk);
      chk("R9 b2b end", {30'd0, res_fault, res_valid}, 32'd0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule